// File: doc/BRIEF.md
# Dual-Clock FIFO with Selectable Read Style

This block carries a stream of data words from a write clock domain to a read clock domain whose frequency and phase are unrelated to it. Words go into a storage array on the write side. Write and read pointers are kept in binary and in Gray code, and the Gray form crosses into the other domain through a chain of flip-flops whose length is set by a parameter. Each side then works out its own flags. Full and almost-full come from write-clock state only, and empty and almost-empty from read-clock state only. A flag that reports a limit therefore rises at once on its own side, and it clears only after the pointer change from the far side has passed through the synchronizer.

A static parameter chooses the read style. In pull style, a word reaches the data output only on the read-clock edge that accepts a read. In push style (first word falls through), the oldest word already sits on the output while empty is low, and each accepted read moves the next word in. One internal prefetch register is present in both styles. Push style adds a visible head register. These registers hold words outside the array, so usable capacity is one entry above the array depth in pull style and two entries above it in push style.

Writes while full and reads while empty have no effect. Each one sets a sticky error flag that stays high until reset. The almost-full and almost-empty thresholds are elaboration-time parameters.

Top module: `dcfifo`

## Requirements
- R1: Every write accepted while full_o is low is delivered exactly once on rd_data_o, in write order, with write and read clocks unrelated.
- R2: With RD_MODE = RD_STD (0), rd_data_o changes only on a read-clock edge where rd_en_i is high and empty_o is low, and it then shows the next word. Before the first such read it keeps its reset value of zero.
- R3: With RD_MODE = RD_FWFT (1), rd_data_o already holds the oldest stored word whenever empty_o is low, with no read needed. A read accepted at an edge replaces it with the following word.
- R4: With DEPTH = 2**ADDR_W, the block holds DEPTH+1 words in RD_STD mode and DEPTH+2 words in RD_FWFT mode before full_o stops further writes.
- R5: full_o is high exactly when the storage array holds DEPTH words. A write attempted while full_o is high is discarded. ovf_o goes high on such a write and stays high until reset.
- R6: A read attempted while empty_o is high removes nothing and leaves rd_data_o unchanged. udf_o goes high on such a read and stays high until reset.
- R7: empty_o is high at the first read-clock edge after the read that removes the last stored word. After a write into an empty block, empty_o stays high for at least the first two read-clock edges.
- R8: aempty_o is high when the read-side fill level is at most AEMPTY_LVL. The fill level counts the array words visible to the read side plus the words in the output registers.
- R9: afull_o is high when the write side sees AFULL_LVL or more words in the storage array. Words moved into the output registers are not counted.
- R10: While rst_ni is low, empty_o and aempty_o are high, full_o, afull_o, ovf_o and udf_o are low, and rd_data_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write-domain clock |
| rclk_i | input | 1 | Read-domain clock |
| rst_ni | input | 1 | Active-low asynchronous reset for both domains |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Word to store |
| full_o | output | 1 | Storage array full, in the write domain |
| afull_o | output | 1 | Array occupancy at or above AFULL_LVL |
| ovf_o | output | 1 | Sticky flag: a write was attempted while full |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Output word |
| empty_o | output | 1 | No word available to read, in the read domain |
| aempty_o | output | 1 | Read-side level at or below AEMPTY_LVL |
| udf_o | output | 1 | Sticky flag: a read was attempted while empty |

## Verification
The hardest state to reach from the ports is one where the output registers are full while the array holds exactly DEPTH words. Only then does capacity reach DEPTH+1 or DEPTH+2, and the almost-full count then differs from the stored total. The stimulus reaches this state with reads held off and single writes spaced far enough apart that both synchronizers settle between them. After each write it compares full, almost-full, almost-empty and overflow against the count the model predicts, and it samples empty within two read edges of the first write. Streaming phases then use skewed read rates, first to keep the block near full and then to drain it, so that the flags are exercised while pointers are crossing in both directions.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;
endpackage

// File: rtl/dcf_sync.sv
module dcf_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] chain_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DATA_W = 18,
  parameter int ADDR_W = 10
) (
  input  logic              wclk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // entry at raddr is stable while the read side may fetch it
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside #(
  parameter int ADDR_W    = 10,
  parameter int AFULL_LVL = 1000
) (
  input  logic              wclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W:0]   rgray_i,
  output logic              full_o,
  output logic              afull_o,
  output logic              ovf_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] waddr_o,
  output logic [ADDR_W:0]   wgray_o
);
  localparam int PW = ADDR_W + 1;
  localparam logic [PW-1:0] DEPTH_V = PW'(1) << ADDR_W;
  localparam logic [PW-1:0] AFULL_V = PW'(AFULL_LVL);

  logic [PW-1:0] wbin_q, wgray_q, wbin_nxt, rbin, used;
  logic          ovf_q;

  always_comb begin
    for (int i = 0; i < PW; i++) rbin[i] = ^(rgray_i >> i);
  end

  assign used     = wbin_q - rbin;
  assign full_o   = (used == DEPTH_V);
  assign afull_o  = (used >= AFULL_V);
  assign we_o     = wr_en_i & ~full_o;
  assign wbin_nxt = wbin_q + PW'(1);

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q  <= '0;
      wgray_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      if (we_o) begin
        wbin_q  <= wbin_nxt;
        wgray_q <= wbin_nxt ^ (wbin_nxt >> 1);
      end
      if (wr_en_i && full_o) ovf_q <= 1'b1;
    end
  end

  assign waddr_o = wbin_q[ADDR_W-1:0];
  assign wgray_o = wgray_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside #(
  parameter int ADDR_W = 10
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              pop_i,
  input  logic [ADDR_W:0]   wgray_i,
  output logic              core_empty_o,
  output logic [ADDR_W-1:0] raddr_o,
  output logic [ADDR_W:0]   rgray_o,
  output logic [ADDR_W:0]   core_cnt_o
);
  localparam int PW = ADDR_W + 1;

  logic [PW-1:0] rbin_q, rgray_q, rbin_nxt, wbin;

  always_comb begin
    for (int i = 0; i < PW; i++) wbin[i] = ^(wgray_i >> i);
  end

  assign core_empty_o = (rgray_q == wgray_i);
  assign core_cnt_o   = wbin - rbin_q;
  assign rbin_nxt     = rbin_q + PW'(1);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q  <= '0;
      rgray_q <= '0;
    end else if (pop_i && !core_empty_o) begin
      rbin_q  <= rbin_nxt;
      rgray_q <= rbin_nxt ^ (rbin_nxt >> 1);
    end
  end

  assign raddr_o = rbin_q[ADDR_W-1:0];
  assign rgray_o = rgray_q;
endmodule

// File: rtl/dcf_ostage.sv
module dcf_ostage
  import dcf_pkg::*;
#(
  parameter int       DATA_W     = 18,
  parameter int       ADDR_W     = 10,
  parameter int       AEMPTY_LVL = 8,
  parameter rd_mode_e RD_MODE    = RD_STD
) (
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic              core_empty_i,
  input  logic [DATA_W-1:0] mem_data_i,
  input  logic [ADDR_W:0]   core_cnt_i,
  output logic              pop_o,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              udf_o
);
  localparam int LW = ADDR_W + 2;
  localparam logic [LW-1:0] AEMPTY_V = LW'(AEMPTY_LVL);

  logic              pf_v_q;
  logic [DATA_W-1:0] pf_d_q;
  logic              pf_take;
  logic [1:0]        n_stg;
  logic [LW-1:0]     level;
  logic              udf_q;

  // refill the prefetch slot whenever it is free or being drained
  assign pop_o = ~core_empty_i & (~pf_v_q | pf_take);

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_v_q <= 1'b0;
      pf_d_q <= '0;
      udf_q  <= 1'b0;
    end else begin
      if (pop_o) begin
        pf_v_q <= 1'b1;
        pf_d_q <= mem_data_i;
      end else if (pf_take) begin
        pf_v_q <= 1'b0;
      end
      if (rd_en_i && empty_o) udf_q <= 1'b1;
    end
  end

  generate
    if (RD_MODE == RD_FWFT) begin : g_fwft
      logic              hd_v_q;
      logic [DATA_W-1:0] hd_d_q;

      assign pf_take = pf_v_q & (~hd_v_q | rd_en_i);

      always_ff @(posedge rclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hd_v_q <= 1'b0;
          hd_d_q <= '0;
        end else if (pf_take) begin
          hd_v_q <= 1'b1;
          hd_d_q <= pf_d_q;
        end else if (rd_en_i) begin
          hd_v_q <= 1'b0;
        end
      end

      assign empty_o   = ~hd_v_q;
      assign rd_data_o = hd_d_q;
      assign n_stg     = {1'b0, pf_v_q} + {1'b0, hd_v_q};
    end else begin : g_std
      logic [DATA_W-1:0] out_q;

      assign pf_take = pf_v_q & rd_en_i;

      always_ff @(posedge rclk_i or negedge rst_ni) begin
        if (!rst_ni)      out_q <= '0;
        else if (pf_take) out_q <= pf_d_q;
      end

      assign empty_o   = ~pf_v_q;
      assign rd_data_o = out_q;
      assign n_stg     = {1'b0, pf_v_q};
    end
  endgenerate

  assign level    = {1'b0, core_cnt_i} + LW'(n_stg);
  assign aempty_o = (level <= AEMPTY_V);
  assign udf_o    = udf_q;
endmodule

// File: rtl/dcfifo.sv
module dcfifo
  import dcf_pkg::*;
#(
  parameter int       DATA_W      = 18,
  parameter int       ADDR_W      = 10,
  parameter int       AFULL_LVL   = 1000,
  parameter int       AEMPTY_LVL  = 8,
  parameter int       SYNC_STAGES = 2,
  parameter rd_mode_e RD_MODE     = RD_STD
) (
  input  logic              wclk_i,
  input  logic              rclk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              full_o,
  output logic              afull_o,
  output logic              ovf_o,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              empty_o,
  output logic              aempty_o,
  output logic              udf_o
);
  logic              we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [ADDR_W:0]   w_gray, r_gray, w_gray_s, r_gray_s, core_cnt;
  logic              core_empty, pop;
  logic [DATA_W-1:0] mem_data;

  dcf_wside #(.ADDR_W(ADDR_W), .AFULL_LVL(AFULL_LVL)) u_wside (
    .wclk_i (wclk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .rgray_i(r_gray_s),
    .full_o (full_o),
    .afull_o(afull_o),
    .ovf_o  (ovf_o),
    .we_o   (we),
    .waddr_o(waddr),
    .wgray_o(w_gray)
  );

  dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .wclk_i (wclk_i),
    .we_i   (we),
    .waddr_i(waddr),
    .wdata_i(wr_data_i),
    .raddr_i(raddr),
    .rdata_o(mem_data)
  );

  dcf_sync #(.WIDTH(ADDR_W+1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk_i (rclk_i),
    .rst_ni(rst_ni),
    .d_i   (w_gray),
    .q_o   (w_gray_s)
  );

  dcf_sync #(.WIDTH(ADDR_W+1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk_i (wclk_i),
    .rst_ni(rst_ni),
    .d_i   (r_gray),
    .q_o   (r_gray_s)
  );

  dcf_rside #(.ADDR_W(ADDR_W)) u_rside (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .pop_i       (pop),
    .wgray_i     (w_gray_s),
    .core_empty_o(core_empty),
    .raddr_o     (raddr),
    .rgray_o     (r_gray),
    .core_cnt_o  (core_cnt)
  );

  dcf_ostage #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .AEMPTY_LVL(AEMPTY_LVL), .RD_MODE(RD_MODE)
  ) u_ostage (
    .rclk_i      (rclk_i),
    .rst_ni      (rst_ni),
    .rd_en_i     (rd_en_i),
    .core_empty_i(core_empty),
    .mem_data_i  (mem_data),
    .core_cnt_i  (core_cnt),
    .pop_o       (pop),
    .rd_data_o   (rd_data_o),
    .empty_o     (empty_o),
    .aempty_o    (aempty_o),
    .udf_o       (udf_o)
  );
endmodule

// File: rtl/dcf_chk.sv
module dcf_chk
  import dcf_pkg::*;
#(
  parameter int       DATA_W    = 18,
  parameter int       ADDR_W    = 10,
  parameter int       AFULL_LVL = 1000,
  parameter rd_mode_e RD_MODE   = RD_STD
) (
  input logic              wclk_i,
  input logic              rclk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic              full_o,
  input logic              afull_o,
  input logic              ovf_o,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              empty_o,
  input logic              udf_o,
  input logic [ADDR_W:0]   w_gray,
  input logic [ADDR_W:0]   r_gray
);
  // pointer codes crossing domains move by one bit per edge (R1)
  p_gray_wr_r1: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    $countones(w_gray ^ $past(w_gray)) <= 1);
  p_gray_rd_r1: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    $countones(r_gray ^ $past(r_gray)) <= 1);

  p_no_overflow_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    full_o && wr_en_i |=> $stable(w_gray) && ovf_o);
  p_ovf_sticky_r5: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    ovf_o |=> ovf_o);

  p_no_underflow_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    empty_o && rd_en_i |=> udf_o);
  p_udf_sticky_r6: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    udf_o |=> udf_o);

  generate
    if (AFULL_LVL <= (1 << ADDR_W)) begin : g_af
      p_full_implies_afull_r9: assert property (@(posedge wclk_i) disable iff (!rst_ni)
        full_o |-> afull_o);
    end
    if (RD_MODE == RD_STD) begin : g_std
      p_std_hold_r2: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        !(rd_en_i && !empty_o) |=> $stable(rd_data_o));
    end else begin : g_fwft
      p_fwft_hold_r3: assert property (@(posedge rclk_i) disable iff (!rst_ni)
        !empty_o && !rd_en_i |=> $stable(rd_data_o) && !empty_o);
    end
  endgenerate
endmodule

bind dcfifo dcf_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .AFULL_LVL(AFULL_LVL), .RD_MODE(RD_MODE)
) u_chk (
  .wclk_i   (wclk_i),
  .rclk_i   (rclk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .full_o   (full_o),
  .afull_o  (afull_o),
  .ovf_o    (ovf_o),
  .rd_en_i  (rd_en_i),
  .rd_data_o(rd_data_o),
  .empty_o  (empty_o),
  .udf_o    (udf_o),
  .w_gray   (w_gray),
  .r_gray   (r_gray)
);

// File: tb/sim_dcfifo.sv
`timescale 1ns/1ps
module sim_dcfifo;
  import dcf_pkg::*;

  localparam int DW    = 16;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;
  localparam int AF    = 13;
  localparam int AE    = 2;
  localparam int CAP0  = DEPTH + 1;
  localparam int CAP1  = DEPTH + 2;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b0;
  always #2.5 wclk = ~wclk;  // 200 MHz write clock
  always #3.7 rclk = ~rclk;  // unrelated read clock

  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd0 = 1'b0, rd1 = 1'b0;
  logic [DW-1:0] q0, q1;
  logic full0, full1, af0, af1, ovf0, ovf1, emp0, emp1, ae0, ae1, udf0, udf1;

  dcfifo #(.DATA_W(DW), .ADDR_W(AW), .AFULL_LVL(AF), .AEMPTY_LVL(AE),
           .SYNC_STAGES(2), .RD_MODE(RD_STD)) u0 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .full_o(full0), .afull_o(af0), .ovf_o(ovf0),
    .rd_en_i(rd0), .rd_data_o(q0), .empty_o(emp0), .aempty_o(ae0), .udf_o(udf0)
  );

  dcfifo #(.DATA_W(DW), .ADDR_W(AW), .AFULL_LVL(AF), .AEMPTY_LVL(AE),
           .SYNC_STAGES(2), .RD_MODE(RD_FWFT)) u1 (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data),
    .full_o(full1), .afull_o(af1), .ovf_o(ovf1),
    .rd_en_i(rd1), .rd_data_o(q1), .empty_o(emp1), .aempty_o(ae1), .udf_o(udf1)
  );

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] exp0[$], exp1[$];
  logic go0 = 1'b0, go1 = 1'b0, drain_mode = 1'b0;
  int   pct0 = 0, pct1 = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // pull-style monitor: data is due one edge after an accepted read
  logic pend0 = 1'b0;
  always @(negedge rclk) begin
    if (pend0) begin
      if (exp0.size() == 0) chk("R1 std word with empty model", 32'(q0), 32'hFFFF_FFFF);
      else begin
        chk("R1/R2 std order", 32'(q0), 32'(exp0.pop_front()));
        if (drain_mode && exp0.size() == 0) chk("R7 std empty after last read", 32'(emp0), 32'd1);
      end
    end
    rd0   = go0 && (int'($urandom_range(99)) < pct0);
    pend0 = rd0 && !emp0;
  end

  // push-style monitor: head word is visible before the read
  logic last1 = 1'b0;
  always @(negedge rclk) begin
    if (last1) chk("R7 fwft empty after last read", 32'(emp1), 32'd1);
    last1 = 1'b0;
    rd1 = go1 && (int'($urandom_range(99)) < pct1);
    if (rd1 && !emp1) begin
      if (exp1.size() == 0) chk("R1 fwft word with empty model", 32'(q1), 32'hFFFF_FFFF);
      else begin
        chk("R1/R3 fwft order", 32'(q1), 32'(exp1.pop_front()));
        last1 = drain_mode && (exp1.size() == 0);
      end
    end
  end

  int cyc = 0;
  always @(posedge wclk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end

  task automatic raw_put(logic [DW-1:0] d);
    @(negedge wclk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic put(logic [DW-1:0] d);
    do @(negedge wclk); while (full0 || full1);
    wr_en = 1'b1;
    wr_data = d;
    exp0.push_back(d);
    exp1.push_back(d);
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  initial begin
    logic [DW-1:0] snap0, snap1;
    int s0, s1, c0, c1;
    repeat (4) @(negedge wclk);
    // R10 reset state
    chk("R10 empty std", 32'(emp0), 1);  chk("R10 empty fwft", 32'(emp1), 1);
    chk("R10 aempty std", 32'(ae0), 1);  chk("R10 aempty fwft", 32'(ae1), 1);
    chk("R10 full", 32'(full0 | full1), 0);
    chk("R10 afull", 32'(af0 | af1), 0);
    chk("R10 ovf/udf", 32'(ovf0 | ovf1 | udf0 | udf1), 0);
    chk("R10 data", 32'(q0 | q1), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge wclk);

    // fill with widely spaced writes, no reads
    for (int k = 1; k <= DEPTH + 3; k++) begin
      raw_put(DW'(16'h1000 + k));
      if (k <= CAP0) exp0.push_back(DW'(16'h1000 + k));
      if (k <= CAP1) exp1.push_back(DW'(16'h1000 + k));
      if (k == 1) begin
        @(negedge rclk);
        chk("R7 std empty held after first write", 32'(emp0), 1);
        chk("R7 fwft empty held after first write", 32'(emp1), 1);
      end
      repeat (24) @(negedge wclk);
      s0 = (k < CAP0) ? k : CAP0;
      s1 = (k < CAP1) ? k : CAP1;
      c0 = (s0 > 1) ? s0 - 1 : 0;
      c1 = (s1 > 2) ? s1 - 2 : 0;
      if (k == 1) begin
        chk("R2 std output waits for read", 32'(q0), 0);
        chk("R3 fwft head word without read", 32'(q1), 32'h1001);
        chk("R7 empty released std", 32'(emp0), 0);
        chk("R7 empty released fwft", 32'(emp1), 0);
      end
      chk("R4/R5 full std", 32'(full0), 32'(s0 == CAP0));
      chk("R4/R5 full fwft", 32'(full1), 32'(s1 == CAP1));
      chk("R5 ovf std", 32'(ovf0), 32'(k > CAP0));
      chk("R5 ovf fwft", 32'(ovf1), 32'(k > CAP1));
      chk("R9 afull std", 32'(af0), 32'(c0 >= AF));
      chk("R9 afull fwft", 32'(af1), 32'(c1 >= AF));
      chk("R8 aempty std", 32'(ae0), 32'(s0 <= AE));
      chk("R8 aempty fwft", 32'(ae1), 32'(s1 <= AE));
    end
    chk("R6 no spurious udf", 32'(udf0 | udf1), 0);

    // drain
    drain_mode = 1'b1;
    pct0 = 60; pct1 = 60; go0 = 1'b1; go1 = 1'b1;
    while (exp0.size() != 0 || exp1.size() != 0) @(negedge rclk);
    go0 = 1'b0; go1 = 1'b0;
    repeat (4) @(negedge rclk);
    drain_mode = 1'b0;
    chk("R7 empty after drain std", 32'(emp0), 1);
    chk("R7 empty after drain fwft", 32'(emp1), 1);
    chk("R8 aempty after drain", 32'(ae0 & ae1), 1);
    chk("R5 full cleared after drain", 32'(full0 | full1), 0);

    // reads against empty
    snap0 = q0; snap1 = q1;
    pct0 = 100; pct1 = 100; go0 = 1'b1; go1 = 1'b1;
    repeat (8) @(negedge rclk);
    go0 = 1'b0; go1 = 1'b0;
    repeat (3) @(negedge rclk);
    chk("R6 std data held on empty read", 32'(q0), 32'(snap0));
    chk("R6 fwft data held on empty read", 32'(q1), 32'(snap1));
    chk("R6 udf std", 32'(udf0), 1);
    chk("R6 udf fwft", 32'(udf1), 1);
    chk("R6 still empty", 32'(emp0 & emp1), 1);

    // streaming: slow reader first to press on full, then fast reader
    pct0 = 15; pct1 = 25; go0 = 1'b1; go1 = 1'b1;
    for (int i = 0; i < 400; i++) begin
      if (i == 200) begin pct0 = 85; pct1 = 95; end
      put(DW'(i * 37 + 5));
      repeat ($urandom_range(2)) @(negedge wclk);
    end
    while (exp0.size() != 0 || exp1.size() != 0) @(negedge rclk);
    go0 = 1'b0; go1 = 1'b0;
    repeat (6) @(negedge rclk);
    chk("R1 stream ends empty", 32'(emp0 & emp1), 1);
    chk("R5 full low at end", 32'(full0 | full1), 0);
    summary();
  end
endmodule